// File: doc/BRIEF.md
# Horizontal Line Event Sequencer

This block paces the work that has to happen at fixed points of every scan line. It keeps a ring of six per-line events and walks it with one pointer. Each event has a 16-bit position in master cycles. The block compares the running master-cycle count with the position of the event that is due next. Once the count reaches that position, the event is serviced, the pointer moves on and the position of the following event is loaded.

Servicing an event produces a one-cycle strobe. Three of the strobes are qualified by the current line number, the visible screen height and an enable for line-driven transfers. The other three are always issued.

The memory-refresh event also raises a stall request. Alongside it the block gives the fixed number of master cycles that the cycle-count owner must add. If the count has already run past several positions, the events are serviced on consecutive clocks until the next position lies ahead of the count. Positions are captured only while reset is held.

Top module: `hsched_top`

## Requirements
- R1: While reset is held, and on the first cycle after it, every strobe output and `stall_req` are low. After reset the first event to be serviced is hblank-start.
- R2: Events are serviced in a fixed cyclic order of indices: 0 hblank-start, 1 hdma-transfer, 2 line-end, 3 hdma-init, 4 render, 5 memory-refresh, then 0 again.
- R3: An event is serviced on a rising clock edge at which `mcyc` is greater than or equal to that event's position. Its strobe is high during the following cycle only. While `mcyc` is below the position, nothing is serviced.
- R4: When `mcyc` is at or past several consecutive positions, one event is serviced per clock, in ring order, until the next event's position exceeds `mcyc`.
- R5: The hdma-transfer strobe is issued only if `hdma_en` is high and `line_num <= scr_height` when the event is serviced. Otherwise the event is passed over silently and the pointer still advances.
- R6: The hdma-init strobe is issued only when `line_num` is 0. Otherwise the event is passed over silently and the pointer still advances.
- R7: The render strobe is issued only when `1 <= line_num <= scr_height`. Together with it, `render_line` carries `line_num - 1`. Otherwise the event is passed over silently.
- R8: Servicing memory-refresh raises `st_refresh` and `stall_req` in the same cycle, and `stall_cycles` reads 40.
- R9: Position inputs are captured only while reset is held. Changes to them after reset have no effect on when events are serviced.
- R10: At most one strobe output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; positions are captured while high |
| pos_in | input | 6x16 | Event positions, indexed by the event order of R2 |
| mcyc | input | 16 | Running master-cycle count within the line |
| line_num | input | 9 | Current line number |
| scr_height | input | 9 | Last visible line number |
| hdma_en | input | 1 | Enables the hdma-transfer strobe |
| st_hblank | output | 1 | Hblank-start strobe |
| st_hdma_xfer | output | 1 | Qualified line-transfer strobe |
| st_line_end | output | 1 | Line-end strobe |
| st_hdma_init | output | 1 | Qualified frame-start transfer setup strobe |
| st_render | output | 1 | Qualified render strobe |
| render_line | output | 9 | Line to render, valid with `st_render` |
| st_refresh | output | 1 | Memory-refresh strobe |
| stall_req | output | 1 | Request to add `stall_cycles` to the count |
| stall_cycles | output | 8 | Refresh stall length in master cycles |

## Verification
The bench uses the default widths (16-bit positions and count, 9-bit lines) with a screen height of 10. This makes the line-0, line-1, last-visible-line and first-blank-line gating cases all reachable within a few short lines.

The positions are spread between 10 and 300 so that a single jump of the count to 200 crosses five positions at once. That exercises the back-to-back servicing and the point where it stops. A changed position set after reset probes the capture-only-in-reset rule.

// File: rtl/hsched_pkg.sv
package hsched_pkg;

    localparam int NUM_EV = 6;

    typedef enum logic [2:0] {
        EV_HBLANK   = 3'd0,
        EV_XFER     = 3'd1,
        EV_LINE_END = 3'd2,
        EV_INIT     = 3'd3,
        EV_RENDER   = 3'd4,
        EV_REFRESH  = 3'd5
    } ev_e;

    typedef struct packed {
        logic hblank;
        logic xfer;
        logic line_end;
        logic init;
        logic render;
        logic refresh;
    } ev_strb_t;

    function automatic ev_e ev_next(input ev_e cur);
        case (cur)
            EV_HBLANK:   return EV_XFER;
            EV_XFER:     return EV_LINE_END;
            EV_LINE_END: return EV_INIT;
            EV_INIT:     return EV_RENDER;
            EV_RENDER:   return EV_REFRESH;
            default:     return EV_HBLANK;
        endcase
    endfunction

endpackage

// File: rtl/hsched_posbank.sv
module hsched_posbank
    import hsched_pkg::*;
#(
    parameter int PW  = 16,
    parameter int NEV = NUM_EV
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NEV-1:0][PW-1:0]  pos_in,
    input  ev_e                     sel,
    output logic [PW-1:0]           pos_sel
);
    logic [NEV-1:0][PW-1:0] pos_q;

    // Positions are captured only while reset is held (R9)
    for (genvar g = 0; g < NEV; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) pos_q[g] <= pos_in[g];
        end
    end

    // During reset the raw input is passed so the compare register can load it
    assign pos_sel = rst ? pos_in[sel] : pos_q[sel];

endmodule

// File: rtl/hsched_ring.sv
module hsched_ring
    import hsched_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] mcyc,
    input  logic [PW-1:0] pos_nxt,
    output ev_e           ptr,
    output ev_e           nxt,
    output logic          hit
);
    logic [PW-1:0] cmp_q;

    assign hit = (mcyc >= cmp_q);
    assign nxt = rst ? EV_HBLANK : ev_next(ptr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= EV_HBLANK;
            cmp_q <= pos_nxt;
        end else if (hit) begin
            ptr   <= nxt;
            cmp_q <= pos_nxt;
        end
    end

endmodule

// File: rtl/hsched_gate.sv
module hsched_gate
    import hsched_pkg::*;
#(
    parameter int LW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hit,
    input  ev_e           ptr,
    input  logic [LW-1:0] line_num,
    input  logic [LW-1:0] scr_height,
    input  logic          hdma_en,
    output ev_strb_t      strb,
    output logic [LW-1:0] render_line,
    output logic          stall_req
);
    ev_strb_t strb_d;
    logic     visible;

    assign visible = (line_num <= scr_height);

    always_comb begin
        strb_d = '0;
        if (hit) begin
            case (ptr)
                EV_HBLANK:   strb_d.hblank   = 1'b1;
                EV_XFER:     strb_d.xfer     = hdma_en && visible;
                EV_LINE_END: strb_d.line_end = 1'b1;
                EV_INIT:     strb_d.init     = (line_num == '0);
                EV_RENDER:   strb_d.render   = (line_num != '0) && visible;
                EV_REFRESH:  strb_d.refresh  = 1'b1;
                default:     strb_d          = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strb        <= '0;
            stall_req   <= 1'b0;
            render_line <= '0;
        end else begin
            strb      <= strb_d;
            stall_req <= strb_d.refresh;
            if (strb_d.render) render_line <= line_num - LW'(1);
        end
    end

endmodule

// File: rtl/hsched_top.sv
module hsched_top
    import hsched_pkg::*;
#(
    parameter int PW    = 16,
    parameter int LW    = 9,
    parameter int SW    = 8,
    parameter int STALL = 40
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_EV-1:0][PW-1:0]  pos_in,
    input  logic [PW-1:0]              mcyc,
    input  logic [LW-1:0]              line_num,
    input  logic [LW-1:0]              scr_height,
    input  logic                       hdma_en,
    output logic                       st_hblank,
    output logic                       st_hdma_xfer,
    output logic                       st_line_end,
    output logic                       st_hdma_init,
    output logic                       st_render,
    output logic [LW-1:0]              render_line,
    output logic                       st_refresh,
    output logic                       stall_req,
    output logic [SW-1:0]              stall_cycles
);
    ev_e           ptr, nxt;
    logic          hit;
    logic [PW-1:0] pos_nxt;
    ev_strb_t      strb;

    hsched_posbank #(.PW(PW), .NEV(NUM_EV)) u_bank (
        .clk(clk), .rst(rst), .pos_in(pos_in), .sel(nxt), .pos_sel(pos_nxt)
    );

    hsched_ring #(.PW(PW)) u_ring (
        .clk(clk), .rst(rst), .mcyc(mcyc), .pos_nxt(pos_nxt),
        .ptr(ptr), .nxt(nxt), .hit(hit)
    );

    hsched_gate #(.LW(LW)) u_gate (
        .clk(clk), .rst(rst), .hit(hit), .ptr(ptr),
        .line_num(line_num), .scr_height(scr_height), .hdma_en(hdma_en),
        .strb(strb), .render_line(render_line), .stall_req(stall_req)
    );

    assign st_hblank    = strb.hblank;
    assign st_hdma_xfer = strb.xfer;
    assign st_line_end  = strb.line_end;
    assign st_hdma_init = strb.init;
    assign st_render    = strb.render;
    assign st_refresh   = strb.refresh;
    assign stall_cycles = SW'(STALL);

endmodule

// File: rtl/hsched_chk.sv
module hsched_chk #(
    parameter int LW = 9
) (
    input logic          clk,
    input logic          rst,
    input logic [LW-1:0] line_num,
    input logic [LW-1:0] scr_height,
    input logic          hdma_en,
    input logic          st_hblank,
    input logic          st_hdma_xfer,
    input logic          st_line_end,
    input logic          st_hdma_init,
    input logic          st_render,
    input logic [LW-1:0] render_line,
    input logic          st_refresh
);
    logic [5:0] all_st;
    assign all_st = {st_hblank, st_hdma_xfer, st_line_end, st_hdma_init, st_render, st_refresh};

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (all_st == '0));

    a_r10_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(all_st));

    a_r5_xfer_gated: assert property (@(posedge clk) disable iff (rst)
        st_hdma_xfer |-> ($past(hdma_en) && ($past(line_num) <= $past(scr_height))));

    a_r6_init_line_zero: assert property (@(posedge clk) disable iff (rst)
        st_hdma_init |-> ($past(line_num) == '0));

    a_r7_render_value: assert property (@(posedge clk) disable iff (rst)
        st_render |-> (($past(line_num) != '0) && ($past(line_num) <= $past(scr_height))
                       && (render_line == $past(line_num) - LW'(1))));

endmodule

bind hsched_top hsched_chk #(.LW(LW)) u_chk (
    .clk(clk), .rst(rst), .line_num(line_num), .scr_height(scr_height),
    .hdma_en(hdma_en), .st_hblank(st_hblank), .st_hdma_xfer(st_hdma_xfer),
    .st_line_end(st_line_end), .st_hdma_init(st_hdma_init), .st_render(st_render),
    .render_line(render_line), .st_refresh(st_refresh)
);

// File: tb/sim_hsched_top.sv
module sim_hsched_top;
    localparam int H = 10;
    localparam int NONE = 7;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [5:0][15:0]     pos_in;
    logic [15:0]          mcyc = '0;
    logic [8:0]           line_num = '0;
    logic [8:0]           scr_height = 9'(H);
    logic                 hdma_en = 1'b1;
    logic st_hblank, st_hdma_xfer, st_line_end, st_hdma_init, st_render, st_refresh, stall_req;
    logic [8:0]           render_line;
    logic [7:0]           stall_cycles;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    hsched_top u0 (
        .clk(clk), .rst(rst), .pos_in(pos_in), .mcyc(mcyc), .line_num(line_num),
        .scr_height(scr_height), .hdma_en(hdma_en), .st_hblank(st_hblank),
        .st_hdma_xfer(st_hdma_xfer), .st_line_end(st_line_end),
        .st_hdma_init(st_hdma_init), .st_render(st_render), .render_line(render_line),
        .st_refresh(st_refresh), .stall_req(stall_req), .stall_cycles(stall_cycles)
    );

    function automatic int code();
        logic [5:0] v;
        v = {st_refresh, st_render, st_hdma_init, st_line_end, st_hdma_xfer, st_hblank};
        if (v == '0) return NONE;
        if ($countones(v) > 1) return 6;
        for (int i = 0; i < 6; i++) if (v[i]) return i;
        return 6;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock with mcyc unchanged; check which event strobed
    task automatic expect_step(input int exp, input int exp_line, input string req);
        int got;
        @(posedge clk);
        @(negedge clk);
        got = code();
        check(got == exp, req, got, exp);
        if (exp == 4) check(int'(render_line) == exp_line, "R7 render_line", int'(render_line), exp_line);
        check(stall_req == (exp == 5), "R8 stall_req", int'(stall_req), int'(exp == 5));
        if (exp == 5) check(int'(stall_cycles) == 40, "R8 stall_cycles", int'(stall_cycles), 40);
    endtask

    task automatic fire(input int cnt, input int exp, input int exp_line, input string req);
        mcyc = 16'(cnt);
        expect_step(exp, exp_line, req);
    endtask

    // Full ring for one line; expectations from R5, R6, R7
    task automatic run_line(input int ln, input bit en);
        line_num = 9'(ln);
        hdma_en  = en;
        fire(100, 0, 0, "R2 hblank");
        fire(110, (en && ln <= H) ? 1 : NONE, 0, "R5 xfer gate");
        fire(300, 2, 0, "R2 line_end");
        fire(10, (ln == 0) ? 3 : NONE, 0, "R6 init gate");
        fire(20, (ln >= 1 && ln <= H) ? 4 : NONE, ln - 1, "R7 render gate");
        fire(150, 5, 0, "R8 refresh");
    endtask

    task automatic t_reset();
        check(code() == NONE, "R1 in reset", code(), NONE);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(code() == NONE, "R1 after reset", code(), NONE);
        check(stall_req == 1'b0, "R1 stall after reset", int'(stall_req), 0);
    endtask

    task automatic t_threshold();
        line_num = 9'd5;
        hdma_en  = 1'b1;
        fire(99, NONE, 0, "R3 below position");
        fire(100, 0, 0, "R1 R3 hblank first at position");
        expect_step(NONE, 0, "R3 single cycle strobe");
        fire(109, NONE, 0, "R3 below xfer");
        fire(110, 1, 0, "R3 xfer");
        fire(300, 2, 0, "R2 line_end");
        fire(10, NONE, 0, "R6 init off line 5");
        fire(20, 4, 4, "R7 render line 5");
        fire(149, NONE, 0, "R3 below refresh");
        fire(150, 5, 0, "R8 refresh");
    endtask

    task automatic t_lines();
        run_line(0, 1'b1);
        run_line(1, 1'b1);
        run_line(H, 1'b1);
        run_line(H + 1, 1'b1);
        run_line(5, 1'b0);
    endtask

    task automatic t_burst();
        line_num = 9'd1;
        hdma_en  = 1'b1;
        fire(100, 0, 0, "R2 hblank");
        fire(110, 1, 0, "R2 xfer");
        fire(300, 2, 0, "R2 line_end");
        mcyc = 16'd200;
        expect_step(NONE, 0, "R4 burst init skipped");
        expect_step(4, 0, "R4 burst render");
        expect_step(5, 0, "R4 burst refresh");
        expect_step(0, 0, "R4 burst hblank");
        expect_step(1, 0, "R4 burst xfer");
        expect_step(NONE, 0, "R4 burst stops");
        fire(300, 2, 0, "R4 line_end after burst");
        fire(10, NONE, 0, "R6 init off line 1");
        fire(20, 4, 0, "R7 render line 1");
        fire(150, 5, 0, "R8 refresh");
    endtask

    task automatic t_pos_lock();
        pos_in[0] = 16'd50;
        pos_in[5] = 16'd60;
        line_num  = 9'd3;
        fire(60, NONE, 0, "R9 new hblank ignored");
        fire(100, 0, 0, "R9 hblank at captured");
        fire(110, 1, 0, "R2 xfer");
        fire(300, 2, 0, "R2 line_end");
        fire(10, NONE, 0, "R6 init off");
        fire(20, 4, 2, "R7 render line 3");
        fire(140, NONE, 0, "R9 new refresh ignored");
        fire(150, 5, 0, "R9 refresh at captured");
    endtask

    initial begin
        pos_in[0] = 16'd100;
        pos_in[1] = 16'd110;
        pos_in[2] = 16'd300;
        pos_in[3] = 16'd10;
        pos_in[4] = 16'd20;
        pos_in[5] = 16'd150;
        repeat (3) @(posedge clk);
        t_reset();
        t_threshold();
        t_lines();
        t_burst();
        t_pos_lock();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule